// File: doc/BRIEF.md
# Debug Breakpoint Request Arbiter

This block sits between the debug-event sources of a CPU core (address comparators, instruction tags, an external trigger line and a combined trigger-and-arm register write) and the core's exception logic. For every accepted event it decides whether the core gets a background-debug entry request, a software-interrupt request, or nothing. The decision depends on four configuration and status inputs: breakpoint enable, route-to-debug select, debug mode enabled, and debug mode active.

The block holds one outstanding breakpoint at a time. When begin-aligned tracing is selected, an event opens a trace session instead of firing. The breakpoint is then held back until the trace logic reports completion. A held breakpoint stays pending until the core acknowledges it. If the debug firmware returns without acknowledging it, the block issues it again. Debug entry always takes precedence over a software interrupt. This applies when a breakpoint meets a user-code software-interrupt instruction. It also applies when a software-interrupt breakpoint meets a background instruction while debug mode is enabled.

Top module: `brk_arbiter`

## Requirements
- R1: While `brk_en` is 0, no event produces a `dbg_req` or `swi_req` pulse and `brk_pend` stays 0.
- R2: With `brk_en`=1 and `dbg_active`=0, an event is routed to a software interrupt (`swi_req`) when `route_dbg`=0. It is also routed to `swi_req` when `route_dbg`=1 but `dbg_enabled`=0.
- R3: `dbg_req` pulses only for breakpoints issued while `brk_en`=1, `route_dbg`=1, `dbg_enabled`=1 and `dbg_active`=0.
- R4: While `dbg_active`=1, comparator, tag and trigger events are ignored and no breakpoint is generated.
- R5: An immediate breakpoint shows on its output one clock after the event is sampled. The pulse lasts one cycle, and `dbg_req` and `swi_req` are never high together.
- R6: With `trace_defer`=1, an accepted event sets `brk_pend` and opens a trace session. Further events during the session are ignored. The breakpoint pulses one clock after `trace_done` is sampled.
- R7: `arm_trig_wr` issues a breakpoint at once when no trace session is open, even with `trace_defer`=1. During an open session it has no effect.
- R8: A user `swi_instr` produces a `swi_req` pulse one clock later. If a debug-entry breakpoint is issued in the same cycle, that `swi_req` is suppressed.
- R9: A breakpoint routed to software interrupt that coincides with `bgnd_instr` while `dbg_enabled`=1 is dropped. No pulse is produced and `brk_pend` clears.
- R10: `brk_pend` rises together with an issued pulse. It falls one clock after `brk_ack` is sampled, provided no trace completion occurs in that cycle.
- R11: A `dbg_ret` pulse while `brk_pend`=1, no trace session is open and `brk_ack`=0 issues the breakpoint again, routed by the current inputs.
- R12: An active-low asynchronous `rst_n` clears `dbg_req`, `swi_req`, `brk_pend` and the trace session.
- R13: While `brk_pend`=1, new comparator, tag and trigger events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_en | input | 1 | Breakpoint enable |
| route_dbg | input | 1 | 1 selects debug entry as the preferred target |
| dbg_enabled | input | 1 | Background debug mode is enabled |
| dbg_active | input | 1 | Debug firmware is currently running |
| cmp_hit | input | NUM_CMP | Comparator match pulses, one per channel |
| tag_hit | input | NUM_TAG | Tagged-instruction pulses, one per channel |
| ext_trig | input | 1 | External trigger pulse |
| arm_trig_wr | input | 1 | Register write that sets trigger and arm together |
| trace_defer | input | 1 | Begin-aligned tracing: defer breakpoint to trace end |
| trace_done | input | 1 | Trace session complete |
| swi_instr | input | 1 | User-code software-interrupt instruction strobe |
| bgnd_instr | input | 1 | Background instruction strobe |
| dbg_ret | input | 1 | Debug firmware returns to normal execution |
| brk_ack | input | 1 | Core acknowledges the pending breakpoint |
| dbg_req | output | 1 | One-cycle debug entry request |
| swi_req | output | 1 | One-cycle software-interrupt request |
| brk_pend | output | 1 | A breakpoint is waiting or outstanding |

## Verification
A corrupted pending flag shows up within one clock. Either a fresh event produces no pulse when it should, or an event that should be ignored produces one. A stuck flag also shows as a missing re-issue on `dbg_ret`. A wrong trace-session state shows as a pulse appearing without `trace_done`, or as no pulse one clock after it. A routing fault shows in the very pulse that follows the event. The bench therefore sweeps every combination of the four routing inputs over each event source, and checks both the pulse and the following quiet cycle.

// File: rtl/brk_arb_pkg.sv
package brk_arb_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_SWI  = 2'd1,
      ROUTE_DBG  = 2'd2
   } brk_route_e;
endpackage

// File: rtl/brk_route.sv
module brk_route
   import brk_arb_pkg::*;
(
   input  logic       brk_en,
   input  logic       route_dbg,
   input  logic       dbg_enabled,
   input  logic       dbg_active,
   output brk_route_e route
);
   always_comb begin
      if (!brk_en || dbg_active)
         route = ROUTE_NONE;
      else if (route_dbg && dbg_enabled)
         route = ROUTE_DBG;
      else
         route = ROUTE_SWI;
   end
endmodule

// File: rtl/brk_event.sv
module brk_event #(
   parameter int NUM_CMP     = 4,
   parameter int NUM_TAG     = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dbg_active,
   input  logic [NUM_CMP-1:0] cmp_hit,
   input  logic [NUM_TAG-1:0] tag_hit,
   input  logic               ext_trig,
   output logic               new_ev
);
   logic trig_s;

   generate
      if (SYNC_STAGES == 0) begin : g_trig_direct
         assign trig_s = ext_trig;
      end else begin : g_trig_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], ext_trig};
         end
         assign trig_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign new_ev = !dbg_active && ((|cmp_hit) || (|tag_hit) || trig_s);
endmodule

// File: rtl/brk_seq.sv
module brk_seq
   import brk_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  brk_route_e route,
   input  logic       dbg_enabled,
   input  logic       new_ev,
   input  logic       arm_trig_wr,
   input  logic       trace_defer,
   input  logic       trace_done,
   input  logic       swi_instr,
   input  logic       bgnd_instr,
   input  logic       dbg_ret,
   input  logic       brk_ack,
   output logic       dbg_req,
   output logic       swi_req,
   output logic       brk_pend
);
   logic tracing_q, pend_q, dbg_q, swi_q;
   logic idle, fire_now, start_tr, fire_tr, fire_ret, fire;
   logic give_dbg, give_swi, pend_d, tracing_d;

   always_comb begin
      idle      = !pend_q && !tracing_q;
      fire_now  = idle && (arm_trig_wr || (new_ev && !trace_defer));
      start_tr  = idle && !arm_trig_wr && new_ev && trace_defer && (route != ROUTE_NONE);
      fire_tr   = tracing_q && trace_done;
      fire_ret  = pend_q && !tracing_q && dbg_ret && !brk_ack;
      fire      = fire_now || fire_tr || fire_ret;
      give_dbg  = fire && (route == ROUTE_DBG);
      give_swi  = fire && (route == ROUTE_SWI) && !(bgnd_instr && dbg_enabled);
      pend_d    = start_tr || (fire ? (give_dbg || give_swi) : (pend_q && !brk_ack));
      tracing_d = start_tr || (tracing_q && !trace_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tracing_q <= 1'b0;
         pend_q    <= 1'b0;
         dbg_q     <= 1'b0;
         swi_q     <= 1'b0;
      end else begin
         tracing_q <= tracing_d;
         pend_q    <= pend_d;
         dbg_q     <= give_dbg;
         swi_q     <= !give_dbg && (give_swi || swi_instr);
      end
   end

   assign dbg_req  = dbg_q;
   assign swi_req  = swi_q;
   assign brk_pend = pend_q;
endmodule

// File: rtl/brk_arbiter.sv
module brk_arbiter
   import brk_arb_pkg::*;
#(
   parameter int NUM_CMP     = 4,
   parameter int NUM_TAG     = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               brk_en,
   input  logic               route_dbg,
   input  logic               dbg_enabled,
   input  logic               dbg_active,
   input  logic [NUM_CMP-1:0] cmp_hit,
   input  logic [NUM_TAG-1:0] tag_hit,
   input  logic               ext_trig,
   input  logic               arm_trig_wr,
   input  logic               trace_defer,
   input  logic               trace_done,
   input  logic               swi_instr,
   input  logic               bgnd_instr,
   input  logic               dbg_ret,
   input  logic               brk_ack,
   output logic               dbg_req,
   output logic               swi_req,
   output logic               brk_pend
);
   generate
      if (NUM_CMP < 1 || NUM_CMP > 16) begin : g_bad_cmp
         $error("brk_arbiter: NUM_CMP must be 1..16");
      end
      if (NUM_TAG < 1 || NUM_TAG > 16) begin : g_bad_tag
         $error("brk_arbiter: NUM_TAG must be 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("brk_arbiter: SYNC_STAGES must be 0..4");
      end
   endgenerate

   brk_route_e route;
   logic       new_ev;

   brk_route u_route (
      .brk_en      (brk_en),
      .route_dbg   (route_dbg),
      .dbg_enabled (dbg_enabled),
      .dbg_active  (dbg_active),
      .route       (route)
   );

   brk_event #(
      .NUM_CMP     (NUM_CMP),
      .NUM_TAG     (NUM_TAG),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_event (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbg_active (dbg_active),
      .cmp_hit    (cmp_hit),
      .tag_hit    (tag_hit),
      .ext_trig   (ext_trig),
      .new_ev     (new_ev)
   );

   brk_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .route       (route),
      .dbg_enabled (dbg_enabled),
      .new_ev      (new_ev),
      .arm_trig_wr (arm_trig_wr),
      .trace_defer (trace_defer),
      .trace_done  (trace_done),
      .swi_instr   (swi_instr),
      .bgnd_instr  (bgnd_instr),
      .dbg_ret     (dbg_ret),
      .brk_ack     (brk_ack),
      .dbg_req     (dbg_req),
      .swi_req     (swi_req),
      .brk_pend    (brk_pend)
   );
endmodule

// File: rtl/brk_arbiter_chk.sv
module brk_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic brk_en,
   input logic route_dbg,
   input logic dbg_enabled,
   input logic dbg_active,
   input logic trace_done,
   input logic brk_ack,
   input logic dbg_req,
   input logic swi_req,
   input logic brk_pend
);
   AST_EXCLUSIVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_req && swi_req)); // R5

   AST_DBG_LEGAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> $past(brk_en && route_dbg && dbg_enabled && !dbg_active)); // R3

   AST_DISABLED_NO_DBG: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_en |=> !dbg_req); // R1

   AST_ACTIVE_NO_DBG: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_active |=> !dbg_req); // R4

   AST_DBG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> brk_pend); // R10

   AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pend && brk_ack && !trace_done) |=> !brk_pend); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!dbg_req && !swi_req && !brk_pend)); // R12
endmodule

bind brk_arbiter brk_arbiter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .brk_en      (brk_en),
   .route_dbg   (route_dbg),
   .dbg_enabled (dbg_enabled),
   .dbg_active  (dbg_active),
   .trace_done  (trace_done),
   .brk_ack     (brk_ack),
   .dbg_req     (dbg_req),
   .swi_req     (swi_req),
   .brk_pend    (brk_pend)
);

// File: tb/sim_brk_arbiter.sv
module sim_brk_arbiter;
   localparam int NC = 4;
   localparam int NT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic brk_en = 0, route_dbg = 0, dbg_enabled = 0, dbg_active = 0;
   logic [NC-1:0] cmp_hit = '0;
   logic [NT-1:0] tag_hit = '0;
   logic ext_trig = 0, arm_trig_wr = 0, trace_defer = 0, trace_done = 0;
   logic swi_instr = 0, bgnd_instr = 0, dbg_ret = 0, brk_ack = 0;
   logic dbg_req, swi_req, brk_pend;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   brk_arbiter #(.NUM_CMP(NC), .NUM_TAG(NT), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .route_dbg(route_dbg),
      .dbg_enabled(dbg_enabled), .dbg_active(dbg_active), .cmp_hit(cmp_hit),
      .tag_hit(tag_hit), .ext_trig(ext_trig), .arm_trig_wr(arm_trig_wr),
      .trace_defer(trace_defer), .trace_done(trace_done), .swi_instr(swi_instr),
      .bgnd_instr(bgnd_instr), .dbg_ret(dbg_ret), .brk_ack(brk_ack),
      .dbg_req(dbg_req), .swi_req(swi_req), .brk_pend(brk_pend)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cfg(input logic en, input logic sel, input logic ena, input logic act);
      brk_en = en; route_dbg = sel; dbg_enabled = ena; dbg_active = act;
   endtask

   task automatic ack();
      brk_ack = 1; tick(); brk_ack = 0;
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      tick(); tick();
      chk("R12", "reset dbg_req", dbg_req, 1'b0);
      chk("R12", "reset swi_req", swi_req, 1'b0);
      chk("R12", "reset brk_pend", brk_pend, 1'b0);
      rst_n = 1; tick();

      // R1 R2 R3 R4 R5 R10: sweep routing inputs over each event source
      for (int src = 0; src < 3; src++) begin
         for (int c = 0; c < 16; c++) begin
            logic en, sel, ena, act, e_dbg, e_swi;
            en = c[3]; sel = c[2]; ena = c[1]; act = c[0];
            e_dbg = en && !act && sel && ena;
            e_swi = en && !act && !(sel && ena);
            cfg(en, sel, ena, act);
            if (src == 0) cmp_hit = NC'(1) << (c % NC);
            else if (src == 1) tag_hit = NT'(1) << (c % NT);
            else ext_trig = 1;
            tick();
            cmp_hit = '0; tag_hit = '0; ext_trig = 0;
            chk(e_dbg ? "R3" : (en ? (act ? "R4" : "R2") : "R1"), "route dbg_req", dbg_req, e_dbg);
            chk(e_swi ? "R2" : (en ? "R4" : "R1"), "route swi_req", swi_req, e_swi);
            chk("R10", "pend with pulse", brk_pend, e_dbg || e_swi);
            dbg_active = 0;
            tick();
            chk("R5", "pulse one cycle", dbg_req || swi_req, 1'b0);
            ack();
            chk("R10", "ack clears pend", brk_pend, 1'b0);
         end
      end

      // R6: deferral to trace completion
      cfg(1, 0, 0, 0); trace_defer = 1;
      cmp_hit = 'b1; tick(); cmp_hit = '0;
      chk("R6", "trace open no pulse", swi_req, 1'b0);
      chk("R6", "trace open pend", brk_pend, 1'b1);
      ext_trig = 1; tick(); ext_trig = 0;
      chk("R6", "event during trace ignored", swi_req, 1'b0);
      trace_done = 1; tick(); trace_done = 0;
      chk("R6", "pulse after trace_done", swi_req, 1'b1);
      ack();
      chk("R10", "pend cleared after trace", brk_pend, 1'b0);

      // R7: trigger-and-arm write ignored during trace, immediate otherwise
      tag_hit = 'b1; tick(); tag_hit = '0;
      arm_trig_wr = 1; tick(); arm_trig_wr = 0;
      chk("R7", "arm write during trace", swi_req, 1'b0);
      trace_done = 1; tick(); trace_done = 0;
      chk("R7", "trace ends normally", swi_req, 1'b1);
      ack();
      arm_trig_wr = 1; tick(); arm_trig_wr = 0;
      chk("R7", "arm write immediate", swi_req, 1'b1);
      chk("R7", "arm write pend", brk_pend, 1'b1);
      ack();
      trace_defer = 0;

      // R8: debug entry beats user SWI; lone SWI passes
      cfg(1, 1, 1, 0);
      cmp_hit = 'b10; swi_instr = 1; tick(); cmp_hit = '0; swi_instr = 0;
      chk("R8", "dbg wins dbg_req", dbg_req, 1'b1);
      chk("R8", "dbg wins swi_req", swi_req, 1'b0);
      // R13: pending blocks new events
      cmp_hit = 'b1; tick(); cmp_hit = '0;
      chk("R13", "event while pending", dbg_req, 1'b0);
      chk("R13", "still pending", brk_pend, 1'b1);
      // R11: unserviced return re-issues
      dbg_ret = 1; tick(); dbg_ret = 0;
      chk("R11", "reissue dbg_req", dbg_req, 1'b1);
      ack();
      chk("R10", "pend after reissue ack", brk_pend, 1'b0);
      swi_instr = 1; tick(); swi_instr = 0;
      chk("R8", "user swi passes", swi_req, 1'b1);
      chk("R8", "user swi no pend", brk_pend, 1'b0);

      // R9: background instruction drops SWI breakpoint
      cfg(1, 0, 1, 0);
      cmp_hit = 'b1; bgnd_instr = 1; tick(); cmp_hit = '0; bgnd_instr = 0;
      chk("R9", "dropped swi_req", swi_req, 1'b0);
      chk("R9", "dropped dbg_req", dbg_req, 1'b0);
      chk("R9", "dropped pend", brk_pend, 1'b0);

      // R12: asynchronous reset mid-run
      ext_trig = 1; tick(); ext_trig = 0;
      chk("R12", "pend before reset", brk_pend, 1'b1);
      #3 rst_n = 0; #1;
      chk("R12", "async clear pend", brk_pend, 1'b0);
      chk("R12", "async clear swi", swi_req, 1'b0);
      tick(); rst_n = 1; tick();
      trace_done = 1; tick(); trace_done = 0;
      chk("R12", "trace session cleared", swi_req, 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule